// File: doc/BRIEF.md
# Serial Fast Command Decoder

This block sits on a single-wire fast command line that carries one bit per clock tick and turns the short bit patterns on it into separate one-cycle strobes for trigger, front-end reset and calibrate. All three patterns begin with a '1'. A lone '1' is a trigger, '11' is a calibrate and '101' is a reset. Because of this, the decoder cannot confirm a trigger on its leading bit. It waits until the two following ticks have ruled out the longer patterns.

Once a pattern has started, the decoder consumes every bit up to the end of that pattern, then looks for a new leading '1'. A busy flag shows when a pattern is in progress. After each decoded reset, a hold-off window of programmable length opens. A trigger decided inside this window is reported on a separate drop strobe and is not emitted as a trigger.

Top module: `fcmd_decoder`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, all strobes and `busy_o` are 0. A reset also cancels any partial pattern and any running hold-off window.
- R2: A '1' followed by a '1' produces `cal_o` high for one cycle. It appears in the cycle after the clock edge that samples the second bit.
- R3: The pattern '1','0','1' produces `rstcmd_o` high for one cycle. It appears in the cycle after the edge that samples the third bit.
- R4: The pattern '1','0','0' produces `trig_o` high for one cycle after the edge that samples the third bit. That edge is two ticks after the leading bit.
- R5: Bits inside a pattern are never taken as a new leading bit. Decoding restarts only on the tick after a pattern completes. For example, '111' followed by '00' gives one calibrate, then one trigger.
- R6: `busy_o` is 1 in every cycle after the edge that sampled a leading '1', up to and including the cycle after the edge that samples the pattern's second-to-last bit. It is 0 otherwise.
- R7: When a reset is decoded at edge r, `hold_len_i` is captured as H. A trigger decided at edge t with t - r <= H pulses `trig_drop_o` instead of `trig_o`. A later change of `hold_len_i` does not affect a window that is already open.
- R8: A trigger decided at t - r > H is emitted normally. H = 0 drops no trigger.
- R9: Every strobe is exactly one cycle wide, and at most one of `trig_o`, `rstcmd_o`, `cal_o`, `trig_drop_o` is high in any cycle.
- R10: Zeros on `cmd_i` outside a pattern produce no strobe and leave `busy_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; `cmd_i` is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 1 | Serial fast command line, one bit per tick |
| hold_len_i | input | HOLD_W | Post-reset trigger hold-off length in cycles |
| trig_o | output | 1 | One-cycle trigger strobe |
| rstcmd_o | output | 1 | One-cycle front-end reset strobe |
| cal_o | output | 1 | One-cycle calibrate strobe |
| trig_drop_o | output | 1 | One-cycle strobe for a trigger dropped in the hold-off window |
| busy_o | output | 1 | A pattern is being decoded |

## Verification
The line is driven with:
- each isolated pattern, which separates the trigger from the calibrate and reset patterns that share its leading bit;
- runs of ones such as '111', '1111' and '10111', which show that bits inside a pattern are consumed and not reread as leading bits;
- back-to-back triggers, which check that the decoder restarts on the very next tick.

After resets, trigger patterns are placed so that their decision edge lands exactly on the last cycle of the hold-off window and on the first cycle after it. A zero-length window is also tried, as is a window whose length input changes after capture. A reset applied in the middle of a pattern checks that the partial pattern is cancelled.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LEAD    = 2'd1,
        ST_LEAD_Z  = 2'd2
    } dec_state_e;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_TRIG = 2'd1,
        KIND_RST  = 2'd2,
        KIND_CAL  = 2'd3
    } cmd_kind_e;

    typedef struct packed {
        logic trig;
        logic rstcmd;
        logic cal;
        logic drop;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{trig: 1'b0, rstcmd: 1'b0, cal: 1'b0, drop: 1'b0};

    // Map a decided command onto strobe lines, diverting triggers while held off.
    function automatic strobe_t kind_to_strobe(cmd_kind_e kind, logic held);
        strobe_t s;
        s = STROBE_IDLE;
        case (kind)
            KIND_TRIG: begin
                s.trig = !held;
                s.drop = held;
            end
            KIND_RST: s.rstcmd = 1'b1;
            KIND_CAL: s.cal    = 1'b1;
            default:  s        = STROBE_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fcmd_pattern_fsm.sv
module fcmd_pattern_fsm
    import fcmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_i,
    output cmd_kind_e kind_o,
    output logic      busy_o
);

    dec_state_e state_q;
    dec_state_e state_d;

    always_comb begin
        state_d = state_q;
        kind_o  = KIND_NONE;
        case (state_q)
            ST_IDLE: begin
                if (bit_i) state_d = ST_LEAD;
            end
            ST_LEAD: begin
                if (bit_i) begin
                    kind_o  = KIND_CAL;
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_LEAD_Z;
                end
            end
            ST_LEAD_Z: begin
                kind_o  = bit_i ? KIND_RST : KIND_TRIG;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/fcmd_holdoff.sv
module fcmd_holdoff #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [HOLD_W-1:0] len_i,
    output logic              active_o
);

    logic [HOLD_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst)                   remain_q <= '0;
        else if (load_i)           remain_q <= len_i;
        else if (remain_q != '0)   remain_q <= remain_q - 1'b1;
    end

    assign active_o = (remain_q != '0);

endmodule

// File: rtl/fcmd_strobe_reg.sv
module fcmd_strobe_reg
    import fcmd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  strobe_t strobe_d,
    input  logic    busy_d,
    output strobe_t strobe_q,
    output logic    busy_q
);

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= STROBE_IDLE;
        else     strobe_q <= strobe_d;
    end

    assign busy_q = busy_d;

endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
    import fcmd_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_i,
    input  logic [HOLD_W-1:0] hold_len_i,
    output logic              trig_o,
    output logic              rstcmd_o,
    output logic              cal_o,
    output logic              trig_drop_o,
    output logic              busy_o
);

    cmd_kind_e kind;
    logic      fsm_busy;
    logic      held;
    strobe_t   strobe_next;
    strobe_t   strobe_now;

    fcmd_pattern_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .bit_i  (cmd_i),
        .kind_o (kind),
        .busy_o (fsm_busy)
    );

    fcmd_holdoff #(.HOLD_W(HOLD_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .load_i   (kind == KIND_RST),
        .len_i    (hold_len_i),
        .active_o (held)
    );

    assign strobe_next = kind_to_strobe(kind, held);

    fcmd_strobe_reg u_out (
        .clk      (clk),
        .rst      (rst),
        .strobe_d (strobe_next),
        .busy_d   (fsm_busy),
        .strobe_q (strobe_now),
        .busy_q   (busy_o)
    );

    assign trig_o      = strobe_now.trig;
    assign rstcmd_o    = strobe_now.rstcmd;
    assign cal_o       = strobe_now.cal;
    assign trig_drop_o = strobe_now.drop;

endmodule

// File: rtl/fcmd_decoder_chk.sv
module fcmd_decoder_chk (
    input logic clk,
    input logic rst,
    input logic cmd_i,
    input logic trig_o,
    input logic rstcmd_o,
    input logic cal_o,
    input logic trig_drop_o,
    input logic busy_o
);

    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({trig_o, rstcmd_o, cal_o, trig_drop_o}));

    assert_trig_width_R9: assert property (@(posedge clk) disable iff (rst)
        trig_o |=> !trig_o);

    assert_cal_width_R9: assert property (@(posedge clk) disable iff (rst)
        cal_o |=> !cal_o);

    assert_cal_bits_R2: assert property (@(posedge clk) disable iff (rst)
        cal_o |-> ($past(cmd_i) && $past(cmd_i, 2)));

    assert_rst_bits_R3: assert property (@(posedge clk) disable iff (rst)
        rstcmd_o |-> ($past(cmd_i) && !$past(cmd_i, 2) && $past(cmd_i, 3)));

    assert_trig_bits_R4: assert property (@(posedge clk) disable iff (rst)
        (trig_o || trig_drop_o) |-> (!$past(cmd_i) && !$past(cmd_i, 2) && $past(cmd_i, 3)));

    assert_busy_lead_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(cmd_i));

endmodule

bind fcmd_decoder fcmd_decoder_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_i       (cmd_i),
    .trig_o      (trig_o),
    .rstcmd_o    (rstcmd_o),
    .cal_o       (cal_o),
    .trig_drop_o (trig_drop_o),
    .busy_o      (busy_o)
);

// File: tb/tb_fcmd_decoder.sv
module tb_fcmd_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD_W     = 8;

    localparam int C_NONE = 0, C_TRIG = 1, C_RST = 2, C_CAL = 3, C_DROP = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd = 1'b0;
    logic [HOLD_W-1:0] hold = 8'd5;
    logic trig, rstcmd, cal, drop, busy;

    fcmd_decoder #(.HOLD_W(HOLD_W)) dut (
        .clk(clk), .rst(rst), .cmd_i(cmd), .hold_len_i(hold),
        .trig_o(trig), .rstcmd_o(rstcmd), .cal_o(cal),
        .trig_drop_o(drop), .busy_o(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { int cyc; int code; string req; } exp_t;
    exp_t q[$];

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit mon_on = 0;
    bit exp_busy = 0;
    bit pend_busy = 0;
    int ms = 0;
    int hold_end = -1;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int obs_code();
        int n = int'(trig) + int'(rstcmd) + int'(cal) + int'(drop);
        if (n > 1)  return 9;
        if (trig)   return C_TRIG;
        if (rstcmd) return C_RST;
        if (cal)    return C_CAL;
        if (drop)   return C_DROP;
        return C_NONE;
    endfunction

    task automatic push(int e, int code, string req);
        exp_t it;
        it.cyc = e; it.code = code; it.req = req;
        q.push_back(it);
    endtask

    // Reference model of the pattern rules, evaluated at sampling edge e.
    task automatic model_step(int e, logic b);
        case (ms)
            0: if (b) ms = 1;
            1: if (b) begin push(e, C_CAL, "R2 R5"); ms = 0; end
               else ms = 2;
            default: begin
                if (b) begin
                    push(e, C_RST, "R3");
                    hold_end = e + int'(hold);
                end else if (e <= hold_end) push(e, C_DROP, "R7");
                else push(e, C_TRIG, "R4 R8");
                ms = 0;
            end
        endcase
        pend_busy = (ms != 0);
    endtask

    task automatic send_bit(logic b);
        @(negedge clk);
        cmd = b;
        model_step(cyc + 1, b);
        @(posedge clk);
        #1 exp_busy = pend_busy;
    endtask

    task automatic send_seq(string s);
        for (int i = 0; i < s.len(); i++) send_bit(s[i] == "1");
    endtask

    task automatic check_idle_r1(string tag);
        n_cmp++;
        if (obs_code() != C_NONE || busy !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 %s: strobes=%0d busy=%b expected strobes=0 busy=0", tag, obs_code(), busy);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cmd = 1'b0;
        ms = 0; hold_end = -1; pend_busy = 0;
        @(posedge clk);
        #1 exp_busy = 0;
        @(negedge clk);
        check_idle_r1("during reset");
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle_r1("after release");
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            while (q.size() > 0 && q[0].cyc < cyc) begin
                n_cmp++; n_bad++;
                $display("FAIL %s: missed strobe at cycle %0d actual=none expected=%0d", q[0].req, q[0].cyc, q[0].code);
                void'(q.pop_front());
            end
            if (q.size() > 0 && q[0].cyc == cyc) begin
                n_cmp++;
                if (obs_code() != q[0].code) begin
                    n_bad++;
                    $display("FAIL %s R9: cycle %0d actual=%0d expected=%0d", q[0].req, cyc, obs_code(), q[0].code);
                end
                void'(q.pop_front());
            end else if (obs_code() != C_NONE) begin
                n_cmp++; n_bad++;
                $display("FAIL R10/R9: cycle %0d actual=%0d expected=%0d", cyc, obs_code(), C_NONE);
            end
            n_cmp++;
            if (busy !== exp_busy) begin
                n_bad++;
                $display("FAIL R6: cycle %0d busy actual=%b expected=%b", cyc, busy, exp_busy);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle_r1("initial reset");
        rst = 1'b0;
        @(negedge clk);
        check_idle_r1("first cycle after release");
        mon_on = 1;

        send_seq("0000");        // R10 idle
        send_seq("11");          // R2
        send_seq("100");         // R4
        send_seq("00");
        // R7: trigger right after reset, then one just outside window (H=5)
        send_seq("101100100");
        // R7 boundary: decision at r+5 dropped, then r+8 emitted
        send_seq("10100100100");
        // R8: decision at r+6 emitted
        send_seq("101000100");
        // R5: bits inside a pattern are consumed
        send_seq("00011100");
        send_seq("000000");
        send_seq("10111");
        send_seq("0000001111");
        send_seq("100100");      // back-to-back triggers
        // R8: zero-length window
        hold = 8'd0;
        send_seq("00101100");
        // R7: window captured at reset, later change ignored
        hold = 8'd200;
        send_seq("101");
        hold = 8'd0;
        send_seq("100");
        send_seq("0");
        // R1: reset in the middle of a pattern and inside a window
        send_seq("1");
        do_reset();
        send_seq("100");
        send_seq("00000");
        repeat (3) @(negedge clk);
        n_cmp++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R9: %0d expected strobes not seen, expected 0", q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule